// File: doc/BRIEF.md
# Four-Bit ALU With Seven-Segment Readout

This block is a purely combinational arithmetic and logic unit. It takes two unsigned 4-bit operands and a 2-bit operation code. It produces one of four results: the wrapped sum, the absolute difference, the bitwise NAND or the bitwise XOR. The chosen 4-bit value goes through a hexadecimal seven-segment decoder to a single digit of an eight-digit common-anode display.

Segment lines and anode enables are both active-low. The rightmost digit is the only one ever selected. The enable input blanks the digit by forcing every segment line high, and it leaves the anode lines unchanged. The two arithmetic results are built from chains of full-adder cells. The absolute difference takes a 5-bit two's-complement subtraction and then negates it when the sign bit is set.

Top module: `seg7_alu`

## Requirements
- R1: With op = 2'b00 the shown value is (a + b) mod 16; the carry out of bit 3 is dropped.
- R2: With op = 2'b01 the shown value is |a − b|, with both operands taken as unsigned.
- R3: With op = 2'b10 the shown value is ~(a & b), computed on each of the 4 bits.
- R4: With op = 2'b11 the shown value is a ^ b, computed on each of the 4 bits.
- R5: When en = 1, seg = {g,f,e,d,c,b,a} (seg[0] is segment a) and is active-low. The values 0..F map to 1000000, 1111001, 0100100, 0110000, 0011001, 0010010, 0000010, 1111000, 0000000, 0010000, 0001000, 0000011, 1000110, 0100001, 0000110, 0001110.
- R6: an is 8'b11111110 at all times, whatever en, op and the operands are. Only digit 0 is enabled, active-low.
- R7: When en = 0, seg is 7'b1111111 (every segment dark), whatever the op and operands are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 4 | First unsigned operand |
| b | input | 4 | Second unsigned operand |
| op | input | 2 | Operation code: 00 sum, 01 absolute difference, 10 NAND, 11 XOR |
| en | input | 1 | Display enable; 0 blanks the digit |
| seg | output | 7 | Active-low segments {g,f,e,d,c,b,a} |
| an | output | 8 | Active-low digit enables, only bit 0 low |

## Verification
No register stands between any input and either output. Every result is therefore due in the same cycle as its stimulus, with zero cycles of latency. The driver changes inputs on the falling clock edge and queues the expected segment and anode values. The monitor pops and compares on the next rising edge, which gives the combinational paths half a period to settle. Each queued item therefore matches the stimulus applied just before it, and no compare ever looks at a value that is still changing.

// File: rtl/seg7_alu_pkg.sv
package seg7_alu_pkg;
  localparam int unsigned NIB_W = 4;
  localparam int unsigned SEG_W = 7;

  typedef enum logic [1:0] {
    OP_ADD     = 2'b00,
    OP_ABSDIFF = 2'b01,
    OP_NAND    = 2'b10,
    OP_XOR     = 2'b11
  } alu_op_e;

  typedef logic [SEG_W-1:0] seg_t;
  localparam seg_t SEG_BLANK = '1;
endpackage

// File: rtl/fa_cell.sv
module fa_cell (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  logic p;
  always_comb begin
    p  = x ^ y;
    s  = p ^ ci;
    co = (x & y) | (p & ci);
  end
endmodule

// File: rtl/ripple_add.sv
module ripple_add #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] s
);
  logic [W-1:0] c;
  assign c[0] = ci;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i < W - 1) begin : g_full
      fa_cell u_fa (
        .x (x[i]),
        .y (y[i]),
        .ci(c[i]),
        .s (s[i]),
        .co(c[i+1])
      );
    end else begin : g_top
      // top carry is not needed by any caller: sum bit only
      assign s[i] = x[i] ^ y[i] ^ c[i];
    end
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import seg7_alu_pkg::*;
#(
  parameter int unsigned W = NIB_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] res
);
  localparam int unsigned WX = W + 1;

  logic [W-1:0]  sum;
  logic [WX-1:0] diff;
  logic [W-1:0]  neg_low;
  logic [W-1:0]  mag;

  ripple_add #(.W(W)) u_sum (
    .x (a),
    .y (b),
    .ci(1'b0),
    .s (sum)
  );

  // a - b on zero-extended operands: a + ~b + 1
  ripple_add #(.W(WX)) u_sub (
    .x ({1'b0, a}),
    .y (~{1'b0, b}),
    .ci(1'b1),
    .s (diff)
  );

  // two's-complement negation of the low bits: ~d + 0 + 1
  ripple_add #(.W(W)) u_neg (
    .x (~diff[W-1:0]),
    .y ('0),
    .ci(1'b1),
    .s (neg_low)
  );

  always_comb begin
    mag = diff[WX-1] ? neg_low : diff[W-1:0];
    unique case (op)
      OP_ADD:     res = sum;
      OP_ABSDIFF: res = mag;
      OP_NAND:    res = ~(a & b);
      OP_XOR:     res = a ^ b;
      default:    res = '0;
    endcase
  end
endmodule

// File: rtl/hex_seg_decoder.sv
module hex_seg_decoder
  import seg7_alu_pkg::*;
(
  input  logic [NIB_W-1:0] nib,
  input  logic             en,
  output seg_t             seg
);
  seg_t shape;
  always_comb begin
    unique case (nib)
      4'h0: shape = 7'b1000000;
      4'h1: shape = 7'b1111001;
      4'h2: shape = 7'b0100100;
      4'h3: shape = 7'b0110000;
      4'h4: shape = 7'b0011001;
      4'h5: shape = 7'b0010010;
      4'h6: shape = 7'b0000010;
      4'h7: shape = 7'b1111000;
      4'h8: shape = 7'b0000000;
      4'h9: shape = 7'b0010000;
      4'hA: shape = 7'b0001000;
      4'hB: shape = 7'b0000011;
      4'hC: shape = 7'b1000110;
      4'hD: shape = 7'b0100001;
      4'hE: shape = 7'b0000110;
      default: shape = 7'b0001110;
    endcase
    seg = en ? shape : SEG_BLANK;
  end
endmodule

// File: rtl/seg7_alu.sv
module seg7_alu
  import seg7_alu_pkg::*;
#(
  parameter int unsigned DIGITS       = 8,
  parameter int unsigned ACTIVE_DIGIT = 0
) (
  input  logic [NIB_W-1:0]  a,
  input  logic [NIB_W-1:0]  b,
  input  logic [1:0]        op,
  input  logic              en,
  output logic [SEG_W-1:0]  seg,
  output logic [DIGITS-1:0] an
);
  logic [NIB_W-1:0] res;

  alu_core #(.W(NIB_W)) u_core (
    .a  (a),
    .b  (b),
    .op (alu_op_e'(op)),
    .res(res)
  );

  hex_seg_decoder u_dec (
    .nib(res),
    .en (en),
    .seg(seg)
  );

  assign an = ~(DIGITS'(1) << ACTIVE_DIGIT);
endmodule

// File: rtl/seg7_alu_chk.sv
module seg7_alu_chk #(
  parameter int unsigned DIGITS = 8
) (
  input logic [3:0]        a,
  input logic [3:0]        b,
  input logic [1:0]        op,
  input logic              en,
  input logic [6:0]        seg,
  input logic [DIGITS-1:0] an
);
  always_comb begin
    AST_ANODE_FIXED: assert ($countones(~an) == 1 && an[0] == 1'b0); // R6
    AST_BLANK_WHEN_OFF: assert (en || seg == 7'b1111111); // R7
    AST_LIT_WHEN_ON: assert (!en || seg != 7'b1111111); // R5
    AST_ADD_ZERO: assert (!(en && op == 2'b00 && a == 4'd0 && b == 4'd0) || seg == 7'b1000000); // R1
    AST_DIFF_SAME: assert (!(en && op == 2'b01 && a == b) || seg == 7'b1000000); // R2
    AST_NAND_DISJOINT: assert (!(en && op == 2'b10 && (a & b) == 4'd0) || seg == 7'b0001110); // R3
    AST_XOR_SAME: assert (!(en && op == 2'b11 && a == b) || seg == 7'b1000000); // R4
  end
endmodule

bind seg7_alu seg7_alu_chk #(.DIGITS(DIGITS)) u_chk (
  .a  (a),
  .b  (b),
  .op (op),
  .en (en),
  .seg(seg),
  .an (an)
);

// File: tb/seg7_alu_bench.sv
module seg7_alu_bench;
  typedef struct {
    logic [6:0] seg;
    logic [7:0] an;
    string      tag;
  } exp_t;

  logic       clk;
  logic       rst_n;
  logic [3:0] a, b;
  logic [1:0] op;
  logic       en;
  logic [6:0] seg;
  logic [7:0] an;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  exp_t q[$];
  bit done = 0;

  seg7_alu u_seg7_alu (.a(a), .b(b), .op(op), .en(en), .seg(seg), .an(an));

  initial clk = 0;
  always #5 clk = ~clk;

  function automatic logic [6:0] shape(input int v);
    case (v)
      0: return 7'b1000000;  1: return 7'b1111001;
      2: return 7'b0100100;  3: return 7'b0110000;
      4: return 7'b0011001;  5: return 7'b0010010;
      6: return 7'b0000010;  7: return 7'b1111000;
      8: return 7'b0000000;  9: return 7'b0010000;
      10: return 7'b0001000; 11: return 7'b0000011;
      12: return 7'b1000110; 13: return 7'b0100001;
      14: return 7'b0000110; default: return 7'b0001110;
    endcase
  endfunction

  function automatic int model(input int x, input int y, input int o);
    case (o)
      0: return (x + y) % 16;
      1: return (x > y) ? x - y : y - x;
      2: return (~(x & y)) & 15;
      default: return (x ^ y) & 15;
    endcase
  endfunction

  task automatic drive(input int x, input int y, input int o, input bit e);
    exp_t it;
    string t;
    @(negedge clk);
    a = 4'(x); b = 4'(y); op = 2'(o); en = e;
    case (o) 0: t = "R1"; 1: t = "R2"; 2: t = "R3"; default: t = "R4"; endcase
    it.seg = e ? shape(model(x, y, o)) : 7'b1111111;
    it.an  = 8'b11111110;
    it.tag = e ? {t, "/R5"} : {t, "/R7"};
    q.push_back(it);
  endtask

  // monitor: results are combinational, due at the edge after the drive
  always @(posedge clk) begin
    if (rst_n && q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      checks++;
      if (seg !== it.seg) begin
        errors++;
        $display("FAIL %s seg: got %b expected %b (a=%0d b=%0d op=%0d en=%0d)",
                 it.tag, seg, it.seg, a, b, op, en);
      end
      checks++;
      if (an !== it.an) begin
        errors++;
        $display("FAIL R6 an: got %b expected %b", an, it.an);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    a = 0; b = 0; op = 0; en = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    // reset-like idle state: en low, digit dark (R7), anode fixed (R6)
    drive(0, 0, 0, 0);
    // sixteen operand pairs, all four operations (R1..R5)
    for (int i = 0; i < 16; i++) begin
      for (int o = 0; o < 4; o++) drive(i, (i * 7 + 3) % 16, o, 1);
    end
    // corners: carry dropped (R1), negative difference (R2), extremes (R3, R4)
    for (int o = 0; o < 4; o++) begin
      drive(15, 15, o, 1);
      drive(0, 15, o, 1);
      drive(15, 0, o, 1);
      drive(9, 9, o, 1);
      drive(1, 14, o, 1);
    end
    // every hex shape through XOR with b=0 (R5)
    for (int v = 0; v < 16; v++) drive(v, 0, 3, 1);
    // blanking for every op with lit-producing operands (R7)
    for (int o = 0; o < 4; o++) drive(8, 3, o, 0);
    drive(6, 6, 1, 0);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule